// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs single register transactions with a PHY over a two-wire management link. One wire is a slow clock that the block generates. The other is a shared data line. A host raises a one-cycle request that carries the direction, the register number and, for a write, a 16-bit value. The block then shifts a 64-bit management frame out on the data line, paced by the generated clock. For a read, it hands the line over to the PHY partway through the frame, collects the PHY's 16 data bits and returns them together with a flag. The flag reports a PHY that did not pull the line low during the handover.

The block keeps the PHY address in a register, and that register holds 00001b after reset. A request with its address-override bit clear reuses the stored address. A request with the bit set replaces the stored address first. The data line is split into a driven value, an output enable and a sampled input, so the pad and any pull-up sit outside the block. The management clock is the system clock divided by twice the `HALF_DIV` parameter. The default of 40 gives 2.5 MHz from a 200 MHz system clock.

Top module: `mdio_master`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `mdc_o`, `mdio_oe_o` and `rd_err_o` are all low.
- R2: Frame bit positions are counted from 0, the first bit sent. Bits 0 to 31 are all ones. Bits 32 and 33 are 0 then 1. Every multi-bit field is sent most-significant bit first.
- R3: Bits 34 and 35 carry the opcode: 1,0 for a read and 0,1 for a write. Bits 36 to 40 carry the PHY address and bits 41 to 45 carry the register address. The controller drives all of bits 0 to 45 for both operations.
- R4: On a write, bits 46 and 47 are driven as 1 then 0. Bits 48 to 63 are driven with `wdata_i`.
- R5: On a read, `mdio_oe_o` is low for bits 46 to 63. The 16 values sampled at the rising MDC edges of bits 48 to 63 appear on `rdata_o` in the same cycle as `done_o`, first sample in bit 15.
- R6: While a frame is in progress, `mdio_o` and `mdio_oe_o` change only at the system clock edge where MDC falls.
- R7: Each MDC high phase and each low phase lasts exactly `HALF_DIV` system clock cycles. A frame contains exactly 64 MDC rising edges, and MDC is low whenever `busy_o` is low.
- R8: On a read, `rd_err_o` goes high at `done_o` if the value sampled for bit 47 is 1, and low if it is 0. A completed write clears `rd_err_o`.
- R9: `busy_o` rises in the cycle after a request is accepted. At the MDC falling edge that ends bit 63, `busy_o` falls and `done_o` is high for exactly one cycle.
- R10: A request raised while `busy_o` is high is ignored. The frame in progress keeps its contents and no second frame follows.
- R11: With `addr_ovr_i` low, a frame uses the stored PHY address, which is 00001b after reset. With `addr_ovr_i` high, `phy_addr_i` is used and then stored for later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe, taken when not busy |
| rd_i | input | 1 | 1 = read, 0 = write |
| addr_ovr_i | input | 1 | Use and store `phy_addr_i` |
| phy_addr_i | input | 5 | PHY address for override |
| reg_addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Last read data |
| rd_err_o | output | 1 | Turnaround error of last read |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line drive value |
| mdio_oe_o | output | 1 | Data line drive enable |
| mdio_i | input | 1 | Data line sampled value |

## Verification
A wrong bit counter or shift register shows up at the ports as a misplaced or corrupted frame bit. It is visible at the first MDC rising edge that samples the bad bit, at most one bit time after the fault. A divider fault shows as a wrong MDC phase length within one phase, or as a missing or extra rising edge by the end of the frame. A fault in read capture or turnaround handling stays hidden until `done_o`, when `rdata_o` or `rd_err_o` disagrees with the values the PHY model drove. Faults in request handling while busy show as changed frame fields or as a second frame starting after completion.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_LEN = 64;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int PRE_LEN   = 32;
  localparam int TA_FIRST  = 46;
  localparam int TA_LAST   = 47;
  localparam int DATA_LEN  = 16;
  localparam int ADDR_W    = 5;

  typedef enum logic [1:0] {
    OPC_WRITE = 2'b01,
    OPC_READ  = 2'b10
  } mdio_opc_e;
endpackage

// File: rtl/mdio_rst_sync.sv
module mdio_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int HALF_DIV = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] CNT_MAX = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          wrap;

  assign wrap = (cnt_q == CNT_MAX);

  always_comb begin
    cnt_d = '0;
    mdc_d = 1'b0;
    if (run_i) begin
      cnt_d = wrap ? '0 : cnt_q + 1'b1;
      mdc_d = wrap ? ~mdc_q : mdc_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc_o  = mdc_q;
  assign rise_o = run_i & wrap & ~mdc_q;
  assign fall_o = run_i & wrap &  mdc_q;

  AST_MDC_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !mdc_q); // R7
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEF_PHY = 5'b00001
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                rd_i,
  input  logic                addr_ovr_i,
  input  logic [ADDR_W-1:0]   phy_addr_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [DATA_LEN-1:0] wdata_i,
  input  logic                rise_i,
  input  logic                fall_i,
  input  logic                mdio_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [DATA_LEN-1:0] rdata_o,
  output logic                rd_err_o,
  output logic                mdio_o,
  output logic                mdio_oe_o
);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] IDX_REL   = IDX_W'(TA_FIRST - 1);
  localparam logic [IDX_W-1:0] IDX_TA2   = IDX_W'(TA_LAST);
  localparam logic [IDX_W-1:0] IDX_DATA0 = IDX_W'(TA_LAST + 1);

  logic                 busy_q, busy_d, done_q, done_d, rd_q, rd_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [FRAME_LEN-1:0] sh_q, sh_d;
  logic [ADDR_W-1:0]    phy_q, phy_d;
  logic [DATA_LEN-1:0]  rx_q, rx_d, rdata_q, rdata_d;
  logic                 err_q, err_d, ta_q, ta_d;
  logic                 oe_q, oe_d, out_q, out_d;
  logic                 accept;
  logic [ADDR_W-1:0]    phy_use;
  logic [FRAME_LEN-1:0] frame;
  mdio_opc_e            opc;

  assign accept  = req_i & ~busy_q;
  assign phy_use = addr_ovr_i ? phy_addr_i : phy_q;
  assign opc     = rd_i ? OPC_READ : OPC_WRITE;
  assign frame   = {{PRE_LEN{1'b1}}, 2'b01, opc, phy_use, reg_addr_i,
                    rd_i ? 2'b11 : 2'b10, rd_i ? {DATA_LEN{1'b1}} : wdata_i};

  always_comb begin
    busy_d  = busy_q;
    done_d  = 1'b0;
    rd_d    = rd_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    phy_d   = phy_q;
    rx_d    = rx_q;
    rdata_d = rdata_q;
    err_d   = err_q;
    ta_d    = ta_q;
    oe_d    = oe_q;
    out_d   = out_q;
    if (accept) begin
      busy_d = 1'b1;
      rd_d   = rd_i;
      idx_d  = '0;
      phy_d  = phy_use;
      out_d  = frame[FRAME_LEN-1];
      sh_d   = {frame[FRAME_LEN-2:0], 1'b0};
      oe_d   = 1'b1;
      ta_d   = 1'b0;
    end else if (busy_q) begin
      if (rise_i && rd_q) begin
        if (idx_q == IDX_TA2)   ta_d = mdio_i;
        if (idx_q >= IDX_DATA0) rx_d = {rx_q[DATA_LEN-2:0], mdio_i};
      end
      if (fall_i) begin
        if (idx_q == IDX_LAST) begin
          busy_d = 1'b0;
          done_d = 1'b1;
          oe_d   = 1'b0;
          out_d  = 1'b1;
          if (rd_q) begin
            rdata_d = rx_q;
            err_d   = ta_q;
          end else begin
            err_d   = 1'b0;
          end
        end else begin
          idx_d = idx_q + 1'b1;
          out_d = sh_q[FRAME_LEN-1];
          sh_d  = {sh_q[FRAME_LEN-2:0], 1'b0};
          if (rd_q && idx_q == IDX_REL) oe_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      rd_q    <= 1'b0;
      idx_q   <= '0;
      sh_q    <= '0;
      phy_q   <= DEF_PHY;
      rx_q    <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
      ta_q    <= 1'b0;
      oe_q    <= 1'b0;
      out_q   <= 1'b1;
    end else begin
      busy_q  <= busy_d;
      done_q  <= done_d;
      rd_q    <= rd_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      phy_q   <= phy_d;
      rx_q    <= rx_d;
      rdata_q <= rdata_d;
      err_q   <= err_d;
      ta_q    <= ta_d;
      oe_q    <= oe_d;
      out_q   <= out_d;
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign rdata_o   = rdata_q;
  assign rd_err_o  = err_q;
  assign mdio_o    = out_q;
  assign mdio_oe_o = oe_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R9
  AST_DONE_AT_BUSY_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $fell(busy_q)); // R9
  AST_DRIVE_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q) && (!$stable(out_q) || !$stable(oe_q))) |-> $past(fall_i)); // R6
  AST_RELEASE_ONLY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $fell(oe_q)) |-> rd_q); // R5
  AST_BUSY_IGNORES_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && req_i) |=> ($stable(rd_q) && $stable(phy_q))); // R10
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int                HALF_DIV = 40,
  parameter logic [ADDR_W-1:0] DEF_PHY  = 5'b00001
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        rd_i,
  input  logic        addr_ovr_i,
  input  logic [4:0]  phy_addr_i,
  input  logic [4:0]  reg_addr_i,
  input  logic [15:0] wdata_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] rdata_o,
  output logic        rd_err_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic rst_n_s, rise, fall, busy;

  mdio_rst_sync i_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_s)
  );

  mdio_clkgen #(.HALF_DIV(HALF_DIV)) i_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .run_i  (busy),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame #(.DEF_PHY(DEF_PHY)) i_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_s),
    .req_i      (req_i),
    .rd_i       (rd_i),
    .addr_ovr_i (addr_ovr_i),
    .phy_addr_i (phy_addr_i),
    .reg_addr_i (reg_addr_i),
    .wdata_i    (wdata_i),
    .rise_i     (rise),
    .fall_i     (fall),
    .mdio_i     (mdio_i),
    .busy_o     (busy),
    .done_o     (done_o),
    .rdata_o    (rdata_o),
    .rd_err_o   (rd_err_o),
    .mdio_o     (mdio_o),
    .mdio_oe_o  (mdio_oe_o)
  );

  assign busy_o = busy;
endmodule

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
module test_mdio_master;
  localparam int HD = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, rd, ovr;
  logic [4:0]  phy, rga;
  logic [15:0] wdat;
  logic        busy, done, rd_err, mdc, mo, moe, mi;
  logic [15:0] rdata;

  int vectors = 0;
  int fails   = 0;
  bit ended   = 0;
  logic [4:0]  cur_phy = 5'b00001;
  logic [15:0] last_rdata = 16'h0;

  always #2.5 clk = ~clk;

  mdio_master #(.HALF_DIV(HD)) i_mdio_master (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .rd_i(rd), .addr_ovr_i(ovr),
    .phy_addr_i(phy), .reg_addr_i(rga), .wdata_i(wdat), .busy_o(busy),
    .done_o(done), .rdata_o(rdata), .rd_err_o(rd_err), .mdc_o(mdc),
    .mdio_o(mo), .mdio_oe_o(moe), .mdio_i(mi)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(input bit r, input logic [4:0] p,
                                            input logic [4:0] a, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, r ? 2'b10 : 2'b01, p, a, 2'b10, d};
  endfunction

  function automatic logic phy_bit(input int n, input bit ta2, input logic [15:0] v);
    if (n == 47) return ta2;
    if (n >= 48) return v[63-n];
    return 1'b1;
  endfunction

  task automatic frame(input bit r, input bit ov, input logic [4:0] p, input logic [4:0] a,
                       input logic [15:0] d, input bit ta2, input logic [15:0] v,
                       input bit inject);
    logic [63:0] bits, oes, ef;
    int rises, c, dones;
    bit prev, inj_on;
    @(negedge clk);
    req = 1'b1; rd = r; ovr = ov; phy = p; rga = a; wdat = d;
    @(negedge clk);
    req = 1'b0;
    chk(busy == 1'b1, "R9", "busy after accept", 64'(busy), 64'd1);
    if (ov) cur_phy = p;
    ef = exp_frame(r, cur_phy, a, d);
    bits = '0; oes = '0; rises = 0; c = 0; dones = 0; prev = mdc; inj_on = 0;
    do begin
      @(negedge clk);
      c++;
      if (inj_on) begin req = 1'b0; inj_on = 0; end
      if (done) dones++;
      if (mdc != prev) begin
        chk(c == HD, "R7", "MDC phase length", 64'(c), 64'(HD));
        c = 0;
        if (mdc) begin
          if (rises < 64) begin bits[63-rises] = mo; oes[63-rises] = moe; end
          rises++;
        end else if (r) begin
          mi = phy_bit(rises, ta2, v);
        end
      end
      prev = mdc;
      if (inject && rises == 10 && c == 1) begin
        req = 1'b1; rd = ~r; ovr = 1'b1; phy = ~p; rga = ~a; wdat = ~d;
        inj_on = 1;
      end
    end while (!done && c < 4*HD);
    mi = 1'b1; req = 1'b0;
    chk(rises == 64, "R7", "MDC rising edges per frame", 64'(rises), 64'd64);
    chk(dones == 1 && busy == 1'b0, "R9", "done with busy fall", {busy, 8'(dones)}, 64'd1);
    chk(bits[63:32] == ef[63:32] && oes[63:32] == '1, "R2", "preamble", bits[63:32], ef[63:32]);
    chk(bits[31:30] == 2'b01 && oes[31:30] == '1, "R2", "start pattern", 64'(bits[31:30]), 64'd1);
    chk(bits[29:28] == ef[29:28] && oes[29:28] == '1, "R3", "opcode", 64'(bits[29:28]), 64'(ef[29:28]));
    chk(bits[27:23] == ef[27:23] && oes[27:23] == '1, "R11", "PHY address", 64'(bits[27:23]), 64'(ef[27:23]));
    chk(bits[22:18] == ef[22:18] && oes[22:18] == '1, "R3", "register address", 64'(bits[22:18]), 64'(ef[22:18]));
    if (!r) begin
      chk(bits[17:0] == ef[17:0] && oes[17:0] == '1, "R4", "turnaround and data", 64'(bits[17:0]), 64'(ef[17:0]));
      chk(rd_err == 1'b0, "R8", "error cleared by write", 64'(rd_err), 64'd0);
      chk(rdata == last_rdata, "R5", "rdata kept on write", 64'(rdata), 64'(last_rdata));
    end else begin
      chk(oes[17:0] == '0, "R5", "line released", 64'(oes[17:0]), 64'd0);
      chk(rdata == v, "R5", "read data", 64'(rdata), 64'(v));
      chk(rd_err == ta2, "R8", "turnaround error", 64'(rd_err), 64'(ta2));
      last_rdata = v;
    end
    repeat (3) begin
      @(negedge clk);
      chk(!busy && !done && !mdc && !moe, "R10", "idle after frame",
          {busy, done, mdc, moe}, 64'd0);
    end
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    req = 0; rd = 0; ovr = 0; phy = 0; rga = 0; wdat = 0; mi = 1'b1;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !mdc && !moe && !rd_err, "R1", "reset state",
        {busy, done, mdc, moe, rd_err}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !mdc && !moe, "R1", "after reset release", {busy, mdc, moe}, 64'd0);
    frame(1, 0, 5'h1F, 5'h01, 16'h0, 0, 16'h8001, 0);   // R11 default address
    frame(0, 0, 5'h00, 5'h1F, 16'hFFFF, 0, 16'h0, 0);   // R4 all ones
    frame(0, 1, 5'h15, 5'h0A, 16'h0000, 0, 16'h0, 0);   // R11 override
    frame(1, 0, 5'h00, 5'h04, 16'h0, 1, 16'h5A5A, 0);   // R8 error
    frame(1, 0, 5'h00, 5'h00, 16'h0, 0, 16'h0000, 0);   // R8 cleared by good read
    frame(0, 0, 5'h03, 5'h11, 16'hC3A5, 0, 16'h0, 1);   // R10 ignored request
    frame(1, 1, 5'h1E, 5'h1E, 16'h0, 0, 16'hFFFE, 1);   // R10 on a read
    for (int k = 0; k < 20; k++) begin
      logic [31:0] x;
      x = $urandom;
      frame(x[0], x[1], 5'($urandom), 5'($urandom), 16'($urandom),
            x[2], 16'($urandom), x[3]);
    end
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!ended) begin
      ended = 1;
      vectors++; fails++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule